// File: doc/BRIEF.md
# Reset Sequencer with Cause Register and Watchdog

This block turns reset causes into one timed reset sequence for a small microcontroller. Every count is in cycles of the reference clock. Three kinds of event can start a sequence:

- a power-on pulse;
- an overflow of the built-in watchdog counter;
- a set of other internal request lines, plus an external low level on the shared open-drain reset pin.

A power-on pulse does not detect brown-out, low voltage or supply glitches. It only reacts to the pulse input.

After power-on, the block first holds the system clock enable low for a long stabilization window. During that window it keeps the reset pin pulled low and the CPU in reset. It then releases the pin, and later the CPU. Any other cause skips the stabilization window. The clocks keep running, the pin is pulled low for a short window, and the CPU stays in reset for a further window before it is released to fetch its reset vector.

The CPU sees the block through a simple bus. A read of the cause register returns the bits that have been recorded and then clears them. A write of any data to the watchdog address clears the watchdog counter. The watchdog is held at zero while the CPU is in reset and starts counting when the CPU is released. Bus accesses are honoured only while the CPU is running.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_pulse` is high, and for STAB_CYCLES (default 4096) rising clock edges after it falls, `clk_en` is 0, `rst_pin_oe` is 1 and `cpu_rst` is 1. Once `clk_en` has risen it stays 1 until the next power-on pulse.
- R2: After power-on, `rst_pin_oe` drops to 0 once STAB_CYCLES + PIN_CYCLES edges (default 4096 + 32) have passed since `por_pulse` fell.
- R3: `cpu_rst` drops to 0 once a further TAIL_CYCLES edges (default 32) have passed after the pin is released. `cpu_rst` is always 1 while `rst_pin_oe` is 1.
- R4: When the CPU is running, a request sampled high on any `src_req` line at an edge starts an internal sequence. `rst_pin_oe` and `cpu_rst` go to 1 after that edge. `rst_pin_oe` stays 1 for PIN_CYCLES edges and `cpu_rst` for PIN_CYCLES + TAIL_CYCLES edges. `clk_en` stays 1 throughout.
- R5: A power-on pulse sets the cause register to 0x80: bit 7 is the power-on bit, and all other bits are cleared. Bit 7 never sets again without another power-on pulse.
- R6: Non-power-on causes each set their own bit, and bits already set are kept. Bit 6 is the pin cause, bit 5 the watchdog cause, and bit i (for i < N_SRC, N_SRC ≤ 5) is `src_req[i]`.
- R7: With the CPU running, a read (`bus_re`) at STAT_ADDR (default 0xFE01) returns the register on `bus_rdata` in the same cycle and clears it at the next edge. A cause that sets a bit in that same cycle survives the clear.
- R8: The watchdog counter is WDOG_W bits wide (default 18) and is held at zero while `cpu_rst` is 1. If it is not cleared, `cpu_rst` rises after the 2^WDOG_W-th edge following the CPU's release, and bit 5 is set.
- R9: With the CPU running, a write (`bus_we`) at WDOG_ADDR (default 0xFFFF) clears the watchdog counter at that edge, whatever the data. A full 2^WDOG_W edges then pass after the write edge before the watchdog reset.
- R10: A request that arrives while the pin or tail window is running restarts the internal sequence from the start of the pin window. A request during the stabilization window does not change any timing, but its cause bit is still recorded.
- R11: While `cpu_rst` is 1, bus reads return 0 and do not clear the cause register.
- R12: A low level on `rst_pin_in` while the CPU is running passes through a two-stage synchronizer. It starts an internal sequence at the third edge after it is first sampled, and sets bit 6. The pin level is ignored in every other phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| por_pulse | input | 1 | Power-on pulse, active high, acts asynchronously |
| src_req | input | N_SRC | Internal reset requests, one per source |
| rst_pin_in | input | 1 | Sensed level of the open-drain reset pin |
| rst_pin_oe | output | 1 | 1 pulls the reset pin low |
| clk_en | output | 1 | Clock enable for the CPU and peripherals |
| cpu_rst | output | 1 | Internal reset to the CPU, active high |
| bus_addr | input | ADDR_W | Bus address |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_rdata | output | 8 | Cause register read data, 0 when not addressed |

## Verification
The assertions check the output ordering on every cycle:
- clocks are never gated unless the pin and CPU resets are also held;
- the pin never releases after the CPU;
- the clock enable never drops again once it has risen;
- the watchdog stays at zero throughout reset;
- the power-on cause bit never comes back by itself.

The exact window lengths, the restart on a late request, the three-edge pin-sense latency, the watchdog period and the clear-on-write all need counted edge positions. The cause-bit values after set, clear and set-during-clear also need them, and only the bench's cycle-by-cycle sweeps show these.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_PIN  = 2'd1,
        PH_TAIL = 2'd2,
        PH_RUN  = 2'd3
    } phase_e;

    localparam int ST_POR = 7;
    localparam int ST_PIN = 6;
    localparam int ST_COP = 5;
    localparam int ST_W   = 8;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sr;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sr = {s_q.sr[STAGES-2:0], din};
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) s_q <= '{sr: '1};
        else     s_q <= s_d;
    end

    assign dout = s_q.sr[STAGES-1];
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int STAB_CYCLES = 4096,
    parameter int PIN_CYCLES  = 32,
    parameter int TAIL_CYCLES = 32
) (
    input  logic   clk,
    input  logic   por,
    input  logic   req,
    output phase_e phase
);
    localparam int CMAX = max3(STAB_CYCLES, PIN_CYCLES, TAIL_CYCLES);
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.ph)
            PH_HOLD: begin
                // Stabilization hold is never shortened by requests.
                if (f_q.cnt == CW'(STAB_CYCLES - 1)) f_d = '{ph: PH_PIN, cnt: '0};
                else                                   f_d.cnt = f_q.cnt + CW'(1);
            end
            PH_PIN: begin
                if (req)                                   f_d = '{ph: PH_PIN, cnt: '0};
                else if (f_q.cnt == CW'(PIN_CYCLES - 1))   f_d = '{ph: PH_TAIL, cnt: '0};
                else                                       f_d.cnt = f_q.cnt + CW'(1);
            end
            PH_TAIL: begin
                if (req)                                   f_d = '{ph: PH_PIN, cnt: '0};
                else if (f_q.cnt == CW'(TAIL_CYCLES - 1))  f_d = '{ph: PH_RUN, cnt: '0};
                else                                       f_d.cnt = f_q.cnt + CW'(1);
            end
            default: begin
                if (req) f_d = '{ph: PH_PIN, cnt: '0};
            end
        endcase
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) f_q <= '{ph: PH_HOLD, cnt: '0};
        else     f_q <= f_d;
    end

    assign phase = f_q.ph;
endmodule

// File: rtl/rstseq_wdog.sv
module rstseq_wdog #(
    parameter int WDOG_W = 18
) (
    input  logic              clk,
    input  logic              por,
    input  logic              hold,
    input  logic              clear,
    output logic [WDOG_W-1:0] count,
    output logic              ovf
);
    typedef struct packed {
        logic [WDOG_W-1:0] cnt;
    } wd_t;

    wd_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (hold || clear) w_d.cnt = '0;
        else               w_d.cnt = w_q.cnt + WDOG_W'(1);
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) w_q <= '{cnt: '0};
        else     w_q <= w_d;
    end

    assign count = w_q.cnt;
    assign ovf   = (w_q.cnt == '1) && !hold && !clear;
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
    import rstseq_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             por,
    input  logic             set_pin,
    input  logic             set_cop,
    input  logic [N_SRC-1:0] set_src,
    input  logic             rd_clr,
    output logic [ST_W-1:0]  stat
);
    typedef struct packed {
        logic [ST_W-1:0] bits;
    } st_t;

    st_t s_d, s_q;
    logic [ST_W-1:0] sets;

    always_comb begin
        sets                = '0;
        sets[N_SRC-1:0]     = set_src;
        sets[ST_COP]        = set_cop;
        sets[ST_PIN]        = set_pin;
        s_d                 = s_q;
        // Sets in the same cycle as a read-clear win.
        s_d.bits            = (rd_clr ? '0 : s_q.bits) | sets;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) s_q <= '{bits: ST_W'(1) << ST_POR};
        else     s_q <= s_d;
    end

    assign stat = s_q.bits;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int                STAB_CYCLES = 4096,
    parameter int                PIN_CYCLES  = 32,
    parameter int                TAIL_CYCLES = 32,
    parameter int                WDOG_W      = 18,
    parameter int                N_SRC       = 2,
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] WDOG_ADDR   = '1,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = ADDR_W'(16'hFE01)
) (
    input  logic              clk,
    input  logic              por_pulse,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              rst_pin_in,
    output logic              rst_pin_oe,
    output logic              clk_en,
    output logic              cpu_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [ST_W-1:0]   bus_rdata
);
    phase_e            phase;
    logic              running;
    logic              pin_s;
    logic              pin_req;
    logic              wd_clr;
    logic              wd_ovf;
    logic              rd_hit;
    logic              req;
    logic [ST_W-1:0]   status_w;
    logic [WDOG_W-1:0] wdog_cnt_w;

    assign running = (phase == PH_RUN);
    assign pin_req = running && !pin_s;
    assign wd_clr  = running && bus_we && (bus_addr == WDOG_ADDR);
    assign rd_hit  = running && bus_re && (bus_addr == STAT_ADDR);
    assign req     = (|src_req) || wd_ovf || pin_req;

    rstseq_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .por  (por_pulse),
        .din  (rst_pin_in),
        .dout (pin_s)
    );

    rstseq_fsm #(
        .STAB_CYCLES (STAB_CYCLES),
        .PIN_CYCLES  (PIN_CYCLES),
        .TAIL_CYCLES (TAIL_CYCLES)
    ) u_fsm (
        .clk   (clk),
        .por   (por_pulse),
        .req   (req),
        .phase (phase)
    );

    rstseq_wdog #(.WDOG_W(WDOG_W)) u_wdog (
        .clk   (clk),
        .por   (por_pulse),
        .hold  (cpu_rst),
        .clear (wd_clr),
        .count (wdog_cnt_w),
        .ovf   (wd_ovf)
    );

    rstseq_status #(.N_SRC(N_SRC)) u_stat (
        .clk     (clk),
        .por     (por_pulse),
        .set_pin (pin_req),
        .set_cop (wd_ovf),
        .set_src (src_req),
        .rd_clr  (rd_hit),
        .stat    (status_w)
    );

    assign clk_en     = (phase != PH_HOLD);
    assign rst_pin_oe = (phase == PH_HOLD) || (phase == PH_PIN);
    assign cpu_rst    = !running;
    assign bus_rdata  = rd_hit ? status_w : '0;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int WDOG_W = 18
) (
    input logic              clk,
    input logic              por_pulse,
    input logic              clk_en,
    input logic              rst_pin_oe,
    input logic              cpu_rst,
    input logic [7:0]        status,
    input logic [WDOG_W-1:0] wdog_cnt
);
    assert_gated_holds_R1: assert property (@(posedge clk) disable iff (por_pulse)
        !clk_en |-> (rst_pin_oe && cpu_rst));

    assert_clk_en_stays_R1: assert property (@(posedge clk) disable iff (por_pulse)
        clk_en |=> clk_en);

    assert_pin_implies_cpu_R3: assert property (@(posedge clk) disable iff (por_pulse)
        rst_pin_oe |-> cpu_rst);

    assert_cpu_after_pin_R3: assert property (@(posedge clk) disable iff (por_pulse)
        $fell(cpu_rst) |-> (!rst_pin_oe && $past(!rst_pin_oe)));

    assert_internal_keeps_clk_R4: assert property (@(posedge clk) disable iff (por_pulse)
        ($rose(rst_pin_oe)) |-> clk_en);

    assert_por_bit_sticky_R5: assert property (@(posedge clk) disable iff (por_pulse)
        !status[7] |=> !status[7]);

    assert_wdog_held_R8: assert property (@(posedge clk) disable iff (por_pulse)
        (cpu_rst && $past(cpu_rst)) |-> (wdog_cnt == '0));
endmodule

bind reset_sequencer rstseq_chk #(.WDOG_W(WDOG_W)) u_chk (
    .clk        (clk),
    .por_pulse  (por_pulse),
    .clk_en     (clk_en),
    .rst_pin_oe (rst_pin_oe),
    .cpu_rst    (cpu_rst),
    .status     (status_w),
    .wdog_cnt   (wdog_cnt_w)
);

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb;
    localparam int STAB = 64;
    localparam int PIN  = 8;
    localparam int TAIL = 8;
    localparam int WW   = 8;
    localparam int NS   = 2;
    localparam logic [15:0] WD_A = 16'hFFFF;
    localparam logic [15:0] ST_A = 16'hFE01;

    logic        clk = 0;
    logic        por_pulse = 1;
    logic [NS-1:0] src_req = '0;
    logic        ext_low = 0;
    logic        rst_pin_in;
    logic        rst_pin_oe, clk_en, cpu_rst;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 0, bus_re = 0;
    logic [7:0]  bus_rdata;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign rst_pin_in = !(rst_pin_oe || ext_low);

    reset_sequencer #(
        .STAB_CYCLES(STAB), .PIN_CYCLES(PIN), .TAIL_CYCLES(TAIL),
        .WDOG_W(WW), .N_SRC(NS), .ADDR_W(16), .WDOG_ADDR(WD_A), .STAT_ADDR(ST_A)
    ) u_dut (
        .clk(clk), .por_pulse(por_pulse), .src_req(src_req), .rst_pin_in(rst_pin_in),
        .rst_pin_oe(rst_pin_oe), .clk_en(clk_en), .cpu_rst(cpu_rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_stat(output logic [7:0] v);
        bus_addr = ST_A;
        bus_re   = 1;
        #1 v = bus_rdata;
        tick();
        bus_re   = 0;
    endtask

    task automatic pulse_src(input int i);
        src_req[i] = 1'b1;
        tick();
        src_req = '0;
    endtask

    task automatic wait_release();
        while (cpu_rst) tick();
    endtask

    // Sweep after an internal request: called with m=1 already reached.
    task automatic sweep_internal(input string tag);
        for (int m = 1; m <= PIN + TAIL + 1; m++) begin
            chk({tag, " R4 pin"}, int'(rst_pin_oe), int'(m <= PIN));
            chk({tag, " R4 cpu"}, int'(cpu_rst), int'(m <= PIN + TAIL));
            chk({tag, " R4 clk_en"}, int'(clk_en), 1);
            tick();
        end
    endtask

    // Power-on sweep from por release; optional request during hold.
    task automatic por_sweep(input bit inject);
        @(negedge clk);
        por_pulse = 0;
        for (int n = 0; n <= STAB + PIN + TAIL + 1; n++) begin
            #1;
            chk("R1 clk_en", int'(clk_en), int'(n >= STAB));
            chk("R2 pin", int'(rst_pin_oe), int'(n < STAB + PIN));
            chk("R3 cpu", int'(cpu_rst), int'(n < STAB + PIN + TAIL));
            if (inject && n == 10) src_req[1] = 1'b1;
            tick();
            src_req = '0;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) tick();
        chk("R1 reset clk_en", int'(clk_en), 0);
        chk("R1 reset pin", int'(rst_pin_oe), 1);
        chk("R1 reset cpu", int'(cpu_rst), 1);

        por_sweep(0);
        read_stat(v); chk("R5 por status", int'(v), 8'h80);
        read_stat(v); chk("R7 cleared", int'(v), 8'h00);

        // Power-on overriding a pending cause; request during hold.
        pulse_src(0);
        por_pulse = 1;
        tick(); tick();
        por_sweep(1);
        read_stat(v); chk("R5 R10 por clears others, hold request recorded", int'(v), 8'h82);

        // Internal request timing.
        pulse_src(1);
        sweep_internal("src1");
        read_stat(v); chk("R4 status src1", int'(v), 8'h02);

        // Cumulative causes.
        pulse_src(0); wait_release();
        pulse_src(1); wait_release();
        read_stat(v); chk("R6 cumulative", int'(v), 8'h03);
        read_stat(v); chk("R7 clear after read", int'(v), 8'h00);

        // Reads during reset are ignored.
        pulse_src(0);
        read_stat(v); chk("R11 read in reset", int'(v), 8'h00);
        wait_release();
        read_stat(v); chk("R11 not cleared", int'(v), 8'h01);

        // Set in the same cycle as the clearing read.
        bus_addr = ST_A; bus_re = 1; src_req[0] = 1'b1;
        #1 chk("R7 read data old value", int'(bus_rdata), 8'h00);
        tick();
        bus_re = 0; src_req = '0;
        wait_release();
        read_stat(v); chk("R7 set beats clear", int'(v), 8'h01);

        // Restart during tail window.
        pulse_src(1);
        repeat (PIN + 2) tick();
        chk("R10 in tail pin", int'(rst_pin_oe), 0);
        chk("R10 in tail cpu", int'(cpu_rst), 1);
        pulse_src(1);
        sweep_internal("restart R10");
        read_stat(v); chk("R10 status", int'(v), 8'h02);

        // External pin low while running.
        ext_low = 1;
        tick();
        ext_low = 0;
        chk("R12 edge1", int'(rst_pin_oe), 0);
        tick();
        chk("R12 edge2", int'(rst_pin_oe), 0);
        tick();
        chk("R12 edge3", int'(rst_pin_oe), 1);
        wait_release();
        read_stat(v); chk("R12 status", int'(v), 8'h40);

        // Watchdog overflow period.
        pulse_src(0);
        wait_release();
        repeat ((1 << WW) - 1) tick();
        chk("R8 before overflow", int'(cpu_rst), 0);
        tick();
        chk("R8 overflow cpu", int'(cpu_rst), 1);
        chk("R8 overflow pin", int'(rst_pin_oe), 1);
        wait_release();
        read_stat(v); chk("R8 R6 status", int'(v), 8'h21);

        // Watchdog clear by write.
        pulse_src(0);
        wait_release();
        repeat (200) tick();
        bus_addr = WD_A; bus_we = 1;
        tick();
        bus_we = 0;
        repeat ((1 << WW) - 1) tick();
        chk("R9 cleared, no reset yet", int'(cpu_rst), 0);
        tick();
        chk("R9 overflow after clear", int'(cpu_rst), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule